// File: doc/BRIEF.md
# Self-Programming Flash Command Controller

This block sits between a processor core and a program-memory model. It holds a small command register. Software arms a self-write command by writing one exact bit pattern into that register. The next store instruction then carries the command out, provided it arrives inside a short window. The command is one of four:

- fill one word of an on-chip page buffer,
- clear that buffer,
- erase a memory page,
- write the buffered page into memory.

A second command arms a configuration read instead. A load instruction inside a three-cycle window then returns either the lock byte or the fuse byte.

If the expected instruction does not come in time, the armed bits clear themselves. Erase and write hand a page address to the memory model and hold a halt signal to the core until the model reports completion.

The memory model reads the page buffer through a separate index port. That port returns the stored word and its valid flag.

Top module: `selfprog_ctl`

## Requirements
- R1: Register bits 7..5 always read as zero; values written to them are ignored.
- R2: Register bits 4..0 are: 4 = clear buffer, 3 = configuration read, 2 = page write, 1 = page erase, 0 = store enable. A write with a legal pattern reads back on the cycle after the write.
- R3: A register write whose low five bits are not exactly 10001, 01001, 00101, 00011 or 00001 leaves the register unchanged.
- R4: A store is honoured in any of the four cycles after the arming write (the fourth included). Without a store, all armed bits read zero from the fifth cycle on.
- R5: With only the enable armed, a store writes the data word into buffer word `ptr[5:1]` and sets that word's valid flag; `ptr[0]` is ignored. The register then clears.
- R6: With erase or page write armed, a store raises `halt` and the matching request (`mem_erase` or `mem_write`) with page `ptr[15:6]`. These stay up until `mem_done`. The data word is not stored.
- R7: During erase or page write the enable bit and the command bit stay set. Both clear on the cycle after `mem_done`, together with `halt`.
- R8: With configuration read armed, a load in one of the three following cycles gives `ld_valid`=1. It returns `lock_bits` if `ptr[0]`=0 and `fuse_bits` if `ptr[0]`=1. After three cycles a load gives `ld_valid`=0.
- R9: A store with the clear command armed resets every buffer valid flag to zero.
- R10: Register writes while `halt` is high are ignored.
- R11: A store with nothing armed changes neither the buffer nor the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Command register write strobe |
| reg_wdata | input | 8 | Command register write value |
| reg_rdata | output | 8 | Command register read value |
| st_strobe | input | 1 | Store instruction executes |
| ld_strobe | input | 1 | Load instruction executes |
| ptr | input | 16 | Address pointer (byte address) |
| wdata | input | 16 | Data word for a buffer fill |
| fuse_bits | input | 8 | Fuse byte from configuration |
| lock_bits | input | 8 | Lock byte from configuration |
| ld_valid | output | 1 | Load returned configuration data |
| ld_data | output | 8 | Configuration byte for the load |
| halt | output | 1 | Core halt while erase or write runs |
| mem_erase | output | 1 | Page erase request, held until done |
| mem_write | output | 1 | Page write request, held until done |
| mem_page | output | 10 | Page address of the request |
| mem_done | input | 1 | Memory model finished the operation |
| buf_idx | input | 5 | Page buffer read index |
| buf_word | output | 16 | Page buffer word at `buf_idx` |
| buf_valid | output | 1 | Valid flag of that word |

## Verification
A timer off by one shows up immediately at the register read port. The armed bits then vanish one cycle early, or linger one cycle into what should be the fifth cycle. Any of these errors appears at the buffer port the cycle after the store that should have caused it:

- a decode error in the mode,
- a store routed to the wrong buffer word,
- a clear that leaves a flag behind.

A wrong busy state shows as `halt` or a request dropping before `mem_done`, or staying high one cycle past it. It also shows as a register write slipping through during the operation.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  localparam int CMD_W = 5;

  localparam logic [CMD_W-1:0] PAT_FILL  = 5'b00001;
  localparam logic [CMD_W-1:0] PAT_ERASE = 5'b00011;
  localparam logic [CMD_W-1:0] PAT_WRITE = 5'b00101;
  localparam logic [CMD_W-1:0] PAT_RDCFG = 5'b01001;
  localparam logic [CMD_W-1:0] PAT_CLEAR = 5'b10001;

  localparam int BIT_EN    = 0;
  localparam int BIT_ERASE = 1;
  localparam int BIT_WRITE = 2;
  localparam int BIT_RDCFG = 3;
  localparam int BIT_CLEAR = 4;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_FILL,
    MODE_ERASE,
    MODE_WRITE,
    MODE_RDCFG,
    MODE_CLEAR
  } mode_e;

  function automatic mode_e decode_mode(input logic [CMD_W-1:0] pat);
    case (pat)
      PAT_FILL:  decode_mode = MODE_FILL;
      PAT_ERASE: decode_mode = MODE_ERASE;
      PAT_WRITE: decode_mode = MODE_WRITE;
      PAT_RDCFG: decode_mode = MODE_RDCFG;
      PAT_CLEAR: decode_mode = MODE_CLEAR;
      default:   decode_mode = MODE_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/selfprog_rstsync.sv
module selfprog_rstsync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/selfprog_pagebuf.sv
module selfprog_pagebuf #(
  parameter int WORDS = 32,
  parameter int DW    = 16,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          clr,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  logic [DW-1:0] data_q [WORDS];
  logic [WORDS-1:0] vld_q, vld_d;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(g));

    always_comb begin
      vld_d[g] = vld_q[g];
      if (clr)      vld_d[g] = 1'b0;
      else if (hit) vld_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   data_q[g] <= '0;
      else if (hit) data_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_data  = data_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));  // R9

  AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> vld_q[$past(wr_idx)]);  // R5

endmodule

// File: rtl/selfprog_cmdreg.sv
module selfprog_cmdreg
  import selfprog_pkg::*;
#(
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN  = 3,
  localparam int CW       = $clog2((STORE_WIN > LOAD_WIN ? STORE_WIN : LOAD_WIN) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [CMD_W-1:0] reg_wbits,
  input  logic             st_strobe,
  input  logic             ld_strobe,
  input  logic             mem_done,
  output logic [CMD_W-1:0] bits,
  output logic             busy,
  output logic             fill_go,
  output logic             clear_go,
  output logic             op_go,
  output logic             rdcfg_armed
);

  logic [CMD_W-1:0] bits_q, bits_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             busy_q, busy_d;
  mode_e            mode_q, mode_wr;
  logic             wr_legal, armed;

  assign mode_q   = decode_mode(bits_q);
  assign mode_wr  = decode_mode(reg_wbits);
  assign wr_legal = (mode_wr != MODE_IDLE);
  assign armed    = bits_q[BIT_EN] && !busy_q;

  always_comb begin
    bits_d   = bits_q;
    cnt_d    = cnt_q;
    busy_d   = busy_q;
    fill_go  = 1'b0;
    clear_go = 1'b0;
    op_go    = 1'b0;
    if (busy_q) begin
      if (mem_done) begin
        bits_d = '0;
        busy_d = 1'b0;
      end
    end else if (reg_we) begin
      if (wr_legal) begin
        bits_d = reg_wbits;
        cnt_d  = (mode_wr == MODE_RDCFG) ? CW'(LOAD_WIN) : CW'(STORE_WIN);
      end
    end else if (armed) begin
      if (mode_q == MODE_RDCFG) begin
        if (ld_strobe || cnt_q == CW'(1)) bits_d = '0;
        else                              cnt_d  = cnt_q - CW'(1);
      end else if (st_strobe) begin
        case (mode_q)
          MODE_FILL: begin
            fill_go = 1'b1;
            bits_d  = '0;
          end
          MODE_CLEAR: begin
            clear_go = 1'b1;
            bits_d   = '0;
          end
          MODE_ERASE, MODE_WRITE: begin
            op_go  = 1'b1;
            busy_d = 1'b1;
          end
          default: bits_d = '0;
        endcase
      end else if (cnt_q == CW'(1)) begin
        bits_d = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign bits        = bits_q;
  assign busy        = busy_q;
  assign rdcfg_armed = armed && (mode_q == MODE_RDCFG);

  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_q == '0) || (mode_q != MODE_IDLE));  // R3

  AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cnt_q == CW'(1) && !reg_we && !st_strobe && !ld_strobe) |=> (bits_q == '0));  // R4

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mem_done) |=> (busy_q && $stable(bits_q)));  // R10

  AST_BUSY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> bits_q[BIT_EN]);  // R7

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mem_done) |=> (!busy_q && bits_q == '0));  // R7

endmodule

// File: rtl/selfprog_ctl.sv
module selfprog_ctl
  import selfprog_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int WORDS     = 32,
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN  = 3,
  localparam int IW       = $clog2(WORDS),
  localparam int PG_LSB   = IW + 1,
  localparam int PW       = AW - PG_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          st_strobe,
  input  logic          ld_strobe,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] wdata,
  input  logic [7:0]    fuse_bits,
  input  logic [7:0]    lock_bits,
  output logic          ld_valid,
  output logic [7:0]    ld_data,
  output logic          halt,
  output logic          mem_erase,
  output logic          mem_write,
  output logic [PW-1:0] mem_page,
  input  logic          mem_done,
  input  logic [IW-1:0] buf_idx,
  output logic [DW-1:0] buf_word,
  output logic          buf_valid
);

  logic             rst_n_s;
  logic [CMD_W-1:0] bits;
  logic             busy, fill_go, clear_go, op_go, rdcfg_armed;
  logic [PW-1:0]    page_q, page_d;

  selfprog_rstsync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  selfprog_cmdreg #(
    .STORE_WIN (STORE_WIN),
    .LOAD_WIN  (LOAD_WIN)
  ) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .reg_we      (reg_we),
    .reg_wbits   (reg_wdata[CMD_W-1:0]),
    .st_strobe   (st_strobe),
    .ld_strobe   (ld_strobe),
    .mem_done    (mem_done),
    .bits        (bits),
    .busy        (busy),
    .fill_go     (fill_go),
    .clear_go    (clear_go),
    .op_go       (op_go),
    .rdcfg_armed (rdcfg_armed)
  );

  selfprog_pagebuf #(
    .WORDS (WORDS),
    .DW    (DW)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (fill_go),
    .wr_idx   (ptr[IW:1]),
    .wr_data  (wdata),
    .clr      (clear_go),
    .rd_idx   (buf_idx),
    .rd_data  (buf_word),
    .rd_valid (buf_valid)
  );

  always_comb begin
    page_d = page_q;
    if (op_go) page_d = ptr[AW-1:PG_LSB];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) page_q <= '0;
    else          page_q <= page_d;
  end

  assign reg_rdata = {{(8-CMD_W){1'b0}}, bits};
  assign halt      = busy;
  assign mem_erase = busy && bits[BIT_ERASE];
  assign mem_write = busy && bits[BIT_WRITE];
  assign mem_page  = page_q;
  assign ld_valid  = ld_strobe && rdcfg_armed;
  assign ld_data   = ld_valid ? (ptr[0] ? fuse_bits : lock_bits) : 8'h00;

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(mem_erase && mem_write));  // R6

  AST_REQ_HALT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_erase || mem_write) |-> halt);  // R6

  AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (halt && !mem_done) |=> $stable(mem_page));  // R6

endmodule

// File: tb/sim_selfprog_ctl.sv
module sim_selfprog_ctl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        st_strobe, ld_strobe;
  logic [15:0] ptr, wdata;
  logic [7:0]  fuse_bits, lock_bits;
  logic        ld_valid;
  logic [7:0]  ld_data;
  logic        halt, mem_erase, mem_write, mem_done;
  logic [9:0]  mem_page;
  logic [4:0]  buf_idx;
  logic [15:0] buf_word;
  logic        buf_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  selfprog_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .st_strobe(st_strobe), .ld_strobe(ld_strobe),
    .ptr(ptr), .wdata(wdata), .fuse_bits(fuse_bits), .lock_bits(lock_bits),
    .ld_valid(ld_valid), .ld_data(ld_data), .halt(halt),
    .mem_erase(mem_erase), .mem_write(mem_write), .mem_page(mem_page),
    .mem_done(mem_done), .buf_idx(buf_idx), .buf_word(buf_word),
    .buf_valid(buf_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic store(input logic [15:0] p, input logic [15:0] d);
    st_strobe = 1'b1; ptr = p; wdata = d;
    @(negedge clk);
    st_strobe = 1'b0;
  endtask

  task automatic peek_buf(input string req, input int idx, input logic vld, input logic [15:0] w);
    buf_idx = 5'(idx);
    #1;
    check(req, {31'd0, buf_valid}, {31'd0, vld});
    if (vld) check(req, {16'd0, buf_word}, {16'd0, w});
  endtask

  task automatic t_reset_and_reserved;
    check("R1 reset", {24'd0, reg_rdata}, 32'h0);
    reg_write(8'hE1);
    check("R1 reserved ignored", {24'd0, reg_rdata}, 32'h01);
    step(4);
    check("R4 expired", {24'd0, reg_rdata}, 32'h0);
  endtask

  task automatic t_illegal;
    reg_write(8'h07);
    check("R3 pattern 00111", {24'd0, reg_rdata}, 32'h0);
    reg_write(8'h10);
    check("R3 pattern 10000", {24'd0, reg_rdata}, 32'h0);
    reg_write(8'h03);
    check("R2 erase armed", {24'd0, reg_rdata}, 32'h03);
    reg_write(8'h19);
    check("R3 illegal keeps old", {24'd0, reg_rdata}, 32'h03);
    step(4);
    check("R4 erase expired", {24'd0, reg_rdata}, 32'h0);
    check("R4 no halt", {31'd0, halt}, 32'h0);
  endtask

  task automatic t_window;
    reg_write(8'h01);
    step(3);
    check("R4 armed on 4th cycle", {24'd0, reg_rdata}, 32'h01);
    store(16'h0007, 16'hBEEF);
    check("R5 cleared after fill", {24'd0, reg_rdata}, 32'h0);
    peek_buf("R5 ptr lsb ignored word3", 3, 1'b1, 16'hBEEF);
    reg_write(8'h01);
    step(4);
    check("R4 gone in 5th cycle", {24'd0, reg_rdata}, 32'h0);
    store(16'h0008, 16'h1234);
    peek_buf("R4 late store dropped", 4, 1'b0, 16'h0);
  endtask

  task automatic t_fill_and_clear;
    reg_write(8'h01);
    store(16'h003E, 16'hA55A);
    peek_buf("R5 word31", 31, 1'b1, 16'hA55A);
    reg_write(8'h01);
    step(1);
    store(16'h0000, 16'h0F0F);
    peek_buf("R5 word0", 0, 1'b1, 16'h0F0F);
    store(16'h0002, 16'h7777);
    peek_buf("R11 unarmed store", 1, 1'b0, 16'h0);
    check("R11 register idle", {24'd0, reg_rdata}, 32'h0);
    reg_write(8'h11);
    check("R2 clear armed", {24'd0, reg_rdata}, 32'h11);
    store(16'h0000, 16'h0000);
    peek_buf("R9 word0 cleared", 0, 1'b0, 16'h0);
    peek_buf("R9 word31 cleared", 31, 1'b0, 16'h0);
    peek_buf("R9 word3 cleared", 3, 1'b0, 16'h0);
    check("R9 register cleared", {24'd0, reg_rdata}, 32'h0);
  endtask

  task automatic t_erase;
    reg_write(8'h01);
    store(16'h0004, 16'h2222);
    reg_write(8'h03);
    step(1);
    store(16'hABC4, 16'hFFFF);
    check("R6 halt", {31'd0, halt}, 32'h1);
    check("R6 erase req", {30'd0, mem_erase, mem_write}, 32'h2);
    check("R6 page", {22'd0, mem_page}, {22'd0, 10'h2AF});
    check("R7 bits held", {24'd0, reg_rdata}, 32'h03);
    peek_buf("R6 data not stored", 2, 1'b1, 16'h2222);
    reg_write(8'h01);
    check("R10 write ignored", {24'd0, reg_rdata}, 32'h03);
    step(5);
    check("R6 still halted", {31'd0, halt}, 32'h1);
    check("R7 still held", {24'd0, reg_rdata}, 32'h03);
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    check("R7 bits cleared", {24'd0, reg_rdata}, 32'h0);
    check("R7 halt released", {31'd0, halt}, 32'h0);
    check("R6 req released", {30'd0, mem_erase, mem_write}, 32'h0);
  endtask

  task automatic t_write;
    reg_write(8'h05);
    step(3);
    store(16'h0040, 16'h0000);
    check("R6 write req", {30'd0, mem_erase, mem_write}, 32'h1);
    check("R6 write page", {22'd0, mem_page}, 32'h1);
    check("R7 write bits", {24'd0, reg_rdata}, 32'h05);
    step(2);
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    check("R7 write done", {23'd0, halt, reg_rdata}, 32'h0);
  endtask

  task automatic t_rdcfg;
    reg_write(8'h09);
    check("R2 rdcfg armed", {24'd0, reg_rdata}, 32'h09);
    ld_strobe = 1'b1; ptr = 16'h0000;
    #1;
    check("R8 lock valid", {31'd0, ld_valid}, 32'h1);
    check("R8 lock data", {24'd0, ld_data}, {24'd0, lock_bits});
    @(negedge clk);
    ld_strobe = 1'b0;
    check("R8 consumed", {24'd0, reg_rdata}, 32'h0);
    reg_write(8'h09);
    step(2);
    ld_strobe = 1'b1; ptr = 16'h0001;
    #1;
    check("R8 fuse 3rd cycle", {23'd0, ld_valid, ld_data}, {23'd0, 1'b1, fuse_bits});
    @(negedge clk);
    ld_strobe = 1'b0;
    reg_write(8'h09);
    step(3);
    ld_strobe = 1'b1; ptr = 16'h0001;
    #1;
    check("R8 expired after 3", {31'd0, ld_valid}, 32'h0);
    @(negedge clk);
    ld_strobe = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00;
    st_strobe = 1'b0; ld_strobe = 1'b0; ptr = 16'h0; wdata = 16'h0;
    fuse_bits = 8'h5C; lock_bits = 8'hC3; mem_done = 1'b0; buf_idx = 5'd0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset_and_reserved();
    t_illegal();
    t_window();
    t_fill_and_clear();
    t_erase();
    t_write();
    t_rdcfg();
    summary();
  end

endmodule